// File: doc/BRIEF.md
# Byte-Addressed Memory Target with Commit-Busy Acknowledge Withholding

This block is a two-wire serial bus target that fronts a small internal byte array. It oversamples the bus clock and data lines with the system clock, detects start and stop conditions, and decodes a 7-bit target address followed by a direction bit. A write transaction carries a two-byte array address (high byte first) followed by any number of data bytes. A read transaction returns bytes starting from a persistent 16-bit pointer. The pointer is not cleared between transactions.

When a stop condition closes a write that stored at least one data byte, the block enters a timed commit window. This window models the slow programming of a nonvolatile array. While the window runs, the target leaves its own address unacknowledged. A host can therefore poll for completion by repeatedly sending the address until it sees an acknowledge. The window length is a parameter in system-clock cycles.

The data line is open-drain. The block only pulls the line low or releases it, and it changes its drive only while the bus clock is low.

Top module: `pollable_mem_target`

## Requirements
- R1: Only an address byte whose upper seven bits equal `DEV_ADDR` is acknowledged: the target pulls SDA low during the ninth clock. Any other address gets no acknowledge, and the target stays silent until the next start or stop.
- R2: After an acknowledged address byte with direction bit 0, the next two bytes load the pointer (high byte, then low byte), masked to the array size. Each later byte is stored at the pointer and acknowledged, and the pointer then advances.
- R3: A stop that ends a write which stored at least one data byte starts a commit window of `COMMIT_CYCLES` system cycles. During the window, an address byte carrying `DEV_ADDR` is not acknowledged, whether its direction bit is 0 or 1.
- R4: Once the commit window has elapsed, the next matching address byte is acknowledged and a normal read or write proceeds.
- R5: The pointer holds the index of the last byte accessed plus one, and it persists across transactions. Reset clears the pointer and every array byte to zero.
- R6: After an acknowledged address byte with direction bit 1, the target shifts out the byte at the pointer, most significant bit first. If the host acknowledges, the target sends the following byte. If the host does not acknowledge, the target releases SDA and waits for a start or stop.
- R7: The pointer wraps from `DEPTH-1` to 0, on both reads and writes.
- R8: The target only pulls SDA low, changes its drive only while SCL is low, and drives nothing in reset or when idle.
- R9: A start or stop arriving in the middle of a byte abandons that byte: a start begins a new address phase, and a stop returns to idle without storing anything. Neither cancels a commit window already running.
- R10: A write that only loads the pointer and then ends with a stop starts no commit window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | High to pull the data line low; low to release it |

## Verification
The SDA drive changes a few system cycles after the synchronised SCL falling edge: two synchroniser stages plus the state register. The bench therefore holds each SCL half-period for eight system cycles and samples the wire in the middle of the high phase, by which time every acknowledge and data bit has settled. Commit timing is measured in system cycles from the stop condition to the first acknowledged poll. The bench checks that this span is at least `COMMIT_CYCLES`, and that it exceeds `COMMIT_CYCLES` by no more than one polling transaction plus margin. Expected acknowledge bits and read bytes are queued by the driver before each bus operation and compared by a monitor in the order the bus produces them.

// File: rtl/pmt_pkg.sv
// Shared types for the pollable memory target.
// Assumes: nothing beyond standard SystemVerilog.
package pmt_pkg;

    localparam int PMT_PTR_W = 16;

    // Bit/byte engine state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SEND,
        ST_HACK,
        ST_WAIT
    } pmt_state_e;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        RL_DEV,
        RL_AHI,
        RL_ALO,
        RL_DATA
    } pmt_role_e;

endpackage

// File: rtl/pmt_line_sampler.sv
// Synchronises the two bus lines and derives clock edges plus start/stop events.
// Assumes: the system clock runs several times faster than the bus clock,
// and SYNC_STAGES >= 2. Idle lines read high.
module pmt_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [SYNC_STAGES-1:0] scl_sy;
    logic [SYNC_STAGES-1:0] sda_sy;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_now;
    logic                   sda_now;

    // Synchroniser chains plus one delayed copy of each line, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
            sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_sy[SYNC_STAGES-1];
            sda_d  <= sda_sy[SYNC_STAGES-1];
        end
    end

    assign scl_now    = scl_sy[SYNC_STAGES-1];
    assign sda_now    = sda_sy[SYNC_STAGES-1];
    assign sda_s_o    = sda_now;
    assign scl_rise_o = scl_now & ~scl_d;
    assign scl_fall_o = ~scl_now & scl_d;
    assign start_o    = scl_now & scl_d & sda_d & ~sda_now;
    assign stop_o     = scl_now & scl_d & ~sda_d & sda_now;

endmodule

// File: rtl/pmt_commit_timer.sv
// Counts down the commit window after a qualifying stop condition.
// Assumes: COMMIT_CYCLES >= 1. A new go pulse reloads the count.
module pmt_commit_timer #(
    parameter int COMMIT_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on go, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (go_i) begin
            cnt_q <= CNT_W'(COMMIT_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/pmt_mem_array.sv
// Byte register file with one synchronous write port and one combinational read port.
// Assumes: DEPTH is a power of two. Every byte resets to zero.
module pmt_mem_array #(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o
);
    logic [7:0] mem_q [DEPTH];

    // Clear all bytes in reset; otherwise store on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else if (we_i) begin
            mem_q[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/pollable_mem_target.sv
// Serial bus memory target. It withholds its address acknowledge during a timed
// commit window that a write-ending stop starts.
// Assumes: DEPTH is a power of two no larger than 65536, and the system clock
// oversamples SCL so that each SCL half-period spans at least four system cycles.
module pollable_mem_target
    import pmt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR      = 7'h50,
    parameter int         DEPTH         = 256,
    parameter int         COMMIT_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int              IDX_W    = $clog2(DEPTH);
    localparam int              PTR_W    = PMT_PTR_W;
    localparam logic [PTR_W-1:0] PTR_MASK = PTR_W'(DEPTH - 1);

    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             busy;
    logic             commit_go;
    logic             mem_we;
    logic [7:0]       rdata;

    pmt_state_e       state_q;
    pmt_role_e        role_q;
    pmt_role_e        role_nxt;
    logic [2:0]       bitcnt_q;
    logic [7:0]       shreg_q;
    logic [7:0]       ahi_q;
    logic             ph_q;
    logic             rw_q;
    logic             wrote_q;
    logic             pull_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_inc;
    logic [7:0]       rx_byte;
    logic [15:0]      addr_full;

    pmt_line_sampler #(.SYNC_STAGES(2)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    pmt_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (commit_go),
        .busy_o (busy)
    );

    pmt_mem_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .idx_i   (ptr_q[IDX_W-1:0]),
        .wdata_i (rx_byte),
        .rdata_o (rdata)
    );

    assign rx_byte    = {shreg_q[6:0], sda_s};
    assign addr_full  = {ahi_q, rx_byte};
    assign ptr_inc    = (ptr_q + PTR_W'(1)) & PTR_MASK;
    assign commit_go  = stop_det & wrote_q;
    assign mem_we     = (state_q == ST_RECV) && scl_rise && (bitcnt_q == 3'd7)
                        && (role_q == RL_DATA);
    assign sda_pull_o = pull_q;

    // Role of the byte that follows an acknowledged one.
    always_comb begin
        unique case (role_q)
            RL_DEV:  role_nxt = RL_AHI;
            RL_AHI:  role_nxt = RL_ALO;
            default: role_nxt = RL_DATA;
        endcase
    end

    // Bit/byte engine: receive, acknowledge, send, and sample the host acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            role_q   <= RL_DEV;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            ahi_q    <= '0;
            ph_q     <= 1'b0;
            rw_q     <= 1'b0;
            wrote_q  <= 1'b0;
            pull_q   <= 1'b0;
            ptr_q    <= '0;
        end else if (start_det) begin
            state_q  <= ST_RECV;
            role_q   <= RL_DEV;
            bitcnt_q <= '0;
            ph_q     <= 1'b0;
            pull_q   <= 1'b0;
        end else if (stop_det) begin
            state_q  <= ST_IDLE;
            pull_q   <= 1'b0;
            wrote_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RECV: if (scl_rise) begin
                    shreg_q  <= rx_byte;
                    bitcnt_q <= bitcnt_q + 3'd1;
                    if (bitcnt_q == 3'd7) begin
                        ph_q    <= 1'b0;
                        state_q <= ST_ACK;
                        unique case (role_q)
                            RL_DEV: begin
                                rw_q <= sda_s;
                                if ((rx_byte[7:1] != DEV_ADDR) || busy) state_q <= ST_WAIT;
                            end
                            RL_AHI:  ahi_q <= rx_byte;
                            RL_ALO:  ptr_q <= addr_full & PTR_MASK;
                            default: begin
                                ptr_q   <= ptr_inc;
                                wrote_q <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: if (scl_fall) begin
                    if (!ph_q) begin
                        pull_q <= 1'b1;
                        ph_q   <= 1'b1;
                    end else begin
                        ph_q     <= 1'b0;
                        bitcnt_q <= '0;
                        if (role_q == RL_DEV && rw_q) begin
                            shreg_q <= rdata;
                            pull_q  <= ~rdata[7];
                            ptr_q   <= ptr_inc;
                            state_q <= ST_SEND;
                        end else begin
                            pull_q  <= 1'b0;
                            role_q  <= role_nxt;
                            state_q <= ST_RECV;
                        end
                    end
                end
                ST_SEND: if (scl_fall) begin
                    bitcnt_q <= bitcnt_q + 3'd1;
                    if (bitcnt_q == 3'd7) begin
                        pull_q  <= 1'b0;
                        ph_q    <= 1'b0;
                        state_q <= ST_HACK;
                    end else begin
                        pull_q  <= ~shreg_q[6];
                        shreg_q <= {shreg_q[6:0], 1'b0};
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        ph_q <= ~sda_s;
                        if (sda_s) state_q <= ST_WAIT;
                    end else if (scl_fall && ph_q) begin
                        shreg_q  <= rdata;
                        pull_q   <= ~rdata[7];
                        ptr_q    <= ptr_inc;
                        bitcnt_q <= '0;
                        ph_q     <= 1'b0;
                        state_q  <= ST_SEND;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pmt_checker.sv
// Protocol and timing properties for the pollable memory target, bound to its top.
// Assumes: it is attached through the bind statement at the end of this file.
module pmt_checker
    import pmt_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_i,
    input logic                 sda_pull_o,
    input pmt_state_e           state_q,
    input pmt_role_e            role_q,
    input logic                 busy,
    input logic                 stop_det,
    input logic [PMT_PTR_W-1:0] ptr_q
);

    // R8: the drive changes only while the bus clock is low.
    p_scl_low_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);

    // R8: the target pulls low only while acknowledging or sending.
    p_pull_in_drive_states_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> (state_q == ST_ACK || state_q == ST_SEND));

    // R3: no acknowledge of the address while the commit window runs.
    p_busy_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(state_q == ST_ACK && role_q == RL_DEV));

    // R3: the commit window opens only right after a stop condition.
    p_commit_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R7: loading a byte to send advances the pointer modulo the array size.
    p_load_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && $past(state_q) != ST_SEND)
        |-> (ptr_q == PMT_PTR_W'((32'($past(ptr_q)) + 32'd1) % DEPTH)));

endmodule

bind pollable_mem_target pmt_checker #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .state_q    (state_q),
    .role_q     (role_q),
    .busy       (busy),
    .stop_det   (stop_det),
    .ptr_q      (ptr_q)
);

// File: tb/pollable_mem_target_tb.sv
// Scoreboard bench: driver tasks queue expected acknowledge bits and read bytes,
// bus tasks queue what they observe, and a monitor process compares the two in order.
module pollable_mem_target_tb_top;
    localparam logic [6:0] DEV    = 7'h50;
    localparam int         DEPTH  = 16;
    localparam int         COMMIT = 2000;
    localparam int         HALF   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_host = 1'b1;
    logic sda_host = 1'b1;
    logic sda_pull;
    logic sda_line;
    int   n_tests = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   last_stop_cyc = 0;

    logic [7:0] exp_val_q [$];
    string      exp_tag_q [$];
    logic [7:0] obs_q     [$];

    assign sda_line = sda_host & ~sda_pull;

    pollable_mem_target #(.DEV_ADDR(DEV), .DEPTH(DEPTH), .COMMIT_CYCLES(COMMIT)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_host),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops observed items and compares them with the expected queue.
    initial begin
        forever begin
            @(posedge clk);
            while (obs_q.size() > 0) begin
                logic [7:0] o;
                o = obs_q.pop_front();
                n_tests++;
                if (exp_val_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL unexpected item actual=%02h expected=none", o);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_val_q.pop_front();
                    t = exp_tag_q.pop_front();
                    if (o !== e) begin
                        n_fail++;
                        $display("FAIL %s actual=%02h expected=%02h", t, o, e);
                    end
                end
            end
        end
    end

    task automatic hc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic v, output logic s);
        sda_host = v;
        hc(HALF);
        scl_host = 1'b1;
        hc(HALF / 2);
        s = sda_line;
        hc(HALF / 2);
        scl_host = 1'b0;
        hc(2);
    endtask

    task automatic i2c_start();
        sda_host = 1'b1;
        hc(HALF);
        scl_host = 1'b1;
        hc(HALF);
        sda_host = 1'b0;
        hc(HALF);
        scl_host = 1'b0;
        hc(HALF);
    endtask

    task automatic i2c_stop();
        sda_host = 1'b0;
        hc(HALF);
        scl_host = 1'b1;
        hc(HALF);
        sda_host = 1'b1;
        last_stop_cyc = cyc;
        hc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic part_bits(input int n);
        logic s;
        for (int i = 0; i < n; i++) bus_bit(i[0], s);
    endtask

    // Driver: queue the expected acknowledge, send, queue the observation.
    task automatic t_send(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        exp_val_q.push_back({7'b0, exp_ack});
        exp_tag_q.push_back(tag);
        send_byte(b, a);
        obs_q.push_back({7'b0, a});
    endtask

    task automatic t_read(input logic [7:0] exp, input logic host_ack, input string tag);
        logic [7:0] b;
        logic       s;
        exp_val_q.push_back(exp);
        exp_tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            b[i] = s;
        end
        bus_bit(~host_ack, s);
        obs_q.push_back(b);
    endtask

    // Polls with a write address until acknowledged; leaves the bus after that acknowledge.
    task automatic poll_until_ack(input string tag);
        int   polls = 0;
        int   t0;
        int   elapsed;
        logic a;
        t0 = last_stop_cyc;
        do begin
            i2c_start();
            send_byte({DEV, 1'b0}, a);
            polls++;
            if (!a) i2c_stop();
        end while (!a && polls < 60);
        elapsed = cyc - t0;
        chk(a == 1'b1, {tag, " R4 poll eventually acked"}, int'(a), 1);
        chk(polls >= 2, {tag, " R3 first polls refused"}, polls, 2);
        chk(elapsed >= COMMIT, {tag, " R3 window not shorter"}, elapsed, COMMIT);
        chk(elapsed <= COMMIT + 400, {tag, " R4 ack soon after window"}, elapsed, COMMIT + 400);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        hc(5);
        chk(sda_pull == 1'b0, "R8 released in reset", int'(sda_pull), 0);
        rst_n = 1'b1;
        hc(5);
        chk(sda_pull == 1'b0, "R8 released when idle", int'(sda_pull), 0);

        // R5: current-address read right after reset streams from location 0.
        i2c_start();
        t_send({DEV, 1'b1}, 1'b1, "R1 own address acked");
        t_read(8'h00, 1'b0, "R5 reset array reads zero");
        i2c_stop();

        // R1: a foreign address is ignored.
        i2c_start();
        t_send({7'h51, 1'b0}, 1'b0, "R1 foreign address not acked");
        i2c_stop();

        // R10: an address-only write starts no commit window.
        i2c_start();
        t_send({DEV, 1'b0}, 1'b1, "R2 write address acked");
        t_send(8'h00, 1'b1, "R2 high address acked");
        t_send(8'h03, 1'b1, "R2 low address acked");
        i2c_stop();
        i2c_start();
        t_send({DEV, 1'b1}, 1'b1, "R10 no busy after pointer load");
        t_read(8'h00, 1'b0, "R2 read at loaded pointer");
        i2c_stop();

        // R2: three data bytes at 0x0A.
        i2c_start();
        t_send({DEV, 1'b0}, 1'b1, "R2 write address acked");
        t_send(8'h00, 1'b1, "R2 high address acked");
        t_send(8'h0A, 1'b1, "R2 low address acked");
        t_send(8'hA5, 1'b1, "R2 data byte acked");
        t_send(8'h3C, 1'b1, "R2 data byte acked");
        t_send(8'h7E, 1'b1, "R2 data byte acked");
        i2c_stop();
        begin
            int commit_t0;
            commit_t0 = last_stop_cyc;

            // R3: both direction values refused while busy.
            i2c_start();
            t_send({DEV, 1'b0}, 1'b0, "R3 busy write address refused");
            i2c_stop();
            i2c_start();
            t_send({DEV, 1'b1}, 1'b0, "R3 busy read address refused");
            i2c_stop();

            // R9: an aborted byte does not cancel the commit.
            i2c_start();
            part_bits(4);
            i2c_stop();
            i2c_start();
            t_send({DEV, 1'b0}, 1'b0, "R9 commit survives abort");
            i2c_stop();
            last_stop_cyc = commit_t0;
        end

        // R4, R6: poll, then random read of 0x0A.
        poll_until_ack("first");
        t_send(8'h00, 1'b1, "R4 high address after commit");
        t_send(8'h0A, 1'b1, "R4 low address after commit");
        i2c_start();
        t_send({DEV, 1'b1}, 1'b1, "R6 read address acked");
        t_read(8'hA5, 1'b0, "R6 stored byte read back");
        i2c_stop();

        // R5: pointer persisted at 0x0B.
        i2c_start();
        t_send({DEV, 1'b1}, 1'b1, "R5 read address acked");
        t_read(8'h3C, 1'b0, "R5 current address read");
        i2c_stop();

        // R6: sequential read with host acknowledge.
        i2c_start();
        t_send({DEV, 1'b1}, 1'b1, "R6 read address acked");
        t_read(8'h7E, 1'b1, "R6 sequential first");
        t_read(8'h00, 1'b0, "R6 sequential second");
        i2c_stop();

        // R7: write wraps from index 15 to 0; high address bits masked.
        i2c_start();
        t_send({DEV, 1'b0}, 1'b1, "R7 write address acked");
        t_send(8'h01, 1'b1, "R7 high address acked");
        t_send(8'h0F, 1'b1, "R7 low address acked");
        t_send(8'h11, 1'b1, "R7 data at last index");
        t_send(8'h22, 1'b1, "R7 data wrapped to zero");
        i2c_stop();
        poll_until_ack("wrap");
        t_send(8'h00, 1'b1, "R7 high address acked");
        t_send(8'h0F, 1'b1, "R7 low address acked");
        i2c_start();
        t_send({DEV, 1'b1}, 1'b1, "R7 read address acked");
        t_read(8'h11, 1'b1, "R7 read last index");
        t_read(8'h22, 1'b1, "R7 read wrapped index 0");
        t_read(8'h00, 1'b0, "R7 read index 1");
        i2c_stop();

        // R9: a start mid-address begins a fresh address phase.
        i2c_start();
        t_send({DEV, 1'b0}, 1'b1, "R9 write address acked");
        t_send(8'h00, 1'b1, "R9 high address acked");
        t_send(8'h0A, 1'b1, "R9 low address acked");
        i2c_stop();
        i2c_start();
        part_bits(5);
        i2c_start();
        t_send({DEV, 1'b1}, 1'b1, "R9 address after restart acked");
        t_read(8'hA5, 1'b0, "R9 read after restart");
        i2c_stop();

        // R9: a stop mid-data stores nothing and starts no commit.
        i2c_start();
        t_send({DEV, 1'b0}, 1'b1, "R9 write address acked");
        t_send(8'h00, 1'b1, "R9 high address acked");
        t_send(8'h0B, 1'b1, "R9 low address acked");
        part_bits(4);
        i2c_stop();
        i2c_start();
        t_send({DEV, 1'b1}, 1'b1, "R9 no commit after aborted data");
        t_read(8'h3C, 1'b0, "R9 aborted byte not stored");
        i2c_stop();
        chk(sda_pull == 1'b0, "R8 released after stop", int'(sda_pull), 0);

        hc(10);
        chk(exp_val_q.size() == 0, "scoreboard drained", exp_val_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule